// File: doc/BRIEF.md
# Carrier Detect Qualification Counter

This block decides when a received carrier is strong enough to trust. A threshold comparator outside the block produces one pulse per carrier cycle while the received amplitude is above the detection level. The block counts the rising edges of that comparator output. It raises a carrier flag only after a run of closely spaced edges, and it withdraws the flag when the edges stop arriving. A downstream receiver gates its data with this flag.

Qualification is allowed only while the local transmitter is idle. The transmitter state is shown by an active-low request-to-send input: high means receive mode. Timing is counted in cycles of a 460.8 kHz clock. At that rate the 2.5 ms gap limit is 1152 cycles, a 1200 Hz carrier gives one edge every 384 cycles, and a 2200 Hz carrier gives one edge about every 209 cycles.

Top module: `carrier_qual`

## Requirements
- R1: The flag goes high on the clock edge that processes the RUN_LEN-th (default 4) consecutive counted comparator rising edge. It stays low after only RUN_LEN-1 edges.
- R2: While `rts_n` is low, the flag is low from the next clock edge onward. Comparator edges seen in that time are not counted. Once `rts_n` returns high, a fresh run of RUN_LEN edges is needed.
- R3: Carrier edge trains at 1200 Hz (384-cycle spacing) and at 2200 Hz (209-cycle spacing) both qualify, and the flag stays high while the train continues.
- R4: An edge that arrives at most GAP_CYCLES (default 1152) clocks after the previous counted edge continues the run. An edge that arrives GAP_CYCLES+1 or more clocks later starts a new run with a count of one.
- R5: When GAP_CYCLES+1 clocks pass after a counted edge with no further edge, the flag drops and the run count clears. RUN_LEN new consecutive edges are then needed to raise it again.
- R6: The comparator input passes through a two-stage synchroniser, and only its low-to-high transitions are counted. A level that is held high counts once, however long it lasts.
- R7: A synchronous active-high reset drives the flag low and clears the run count and the gap timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Time-base clock (460.8 kHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| rts_n | input | 1 | Request-to-send, active low; high means receive mode |
| cmp_in | input | 1 | Asynchronous carrier threshold comparator output |
| carrier_ok | output | 1 | Registered carrier-detect flag |

## Verification
Square-wave comparator trains at the 1200 Hz and 2200 Hz spacings show that both carrier tones qualify after exactly four edges and not after three. Trains spaced exactly at the gap limit, followed by one edge a cycle later, locate the boundary of the timeout to the cycle and show that a late edge starts a new run. A long silence after qualification pins the cycle in which the flag drops. A long high level between edges shows that levels are not counted. Pulling request-to-send low during qualification and during a pulse burst shows that transmit mode both clears the flag and discards the edges.

// File: rtl/cdq_pkg.sv
package cdq_pkg;
  // Bits needed to hold values 0..n inclusive
  function automatic int cdq_width(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/cdq_edge_sync.sv
module cdq_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/cdq_gap_timer.sv
module cdq_gap_timer #(
  parameter int GAP_CYCLES = 1152,
  parameter int TW         = cdq_pkg::cdq_width(GAP_CYCLES)
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic expired
);
  localparam logic [TW-1:0] LIMIT = TW'(GAP_CYCLES);

  logic [TW-1:0] elapsed_q;

  // Cycles since the last counted edge, saturating at the limit
  always_ff @(posedge clk) begin
    if (rst)                    elapsed_q <= '0;
    else if (restart)           elapsed_q <= '0;
    else if (elapsed_q != LIMIT) elapsed_q <= elapsed_q + TW'(1);
  end

  assign expired = (elapsed_q == LIMIT);
endmodule

// File: rtl/cdq_run_counter.sv
module cdq_run_counter #(
  parameter int RUN_LEN = 4,
  parameter int CW      = cdq_pkg::cdq_width(RUN_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_mode,
  input  logic          edge_in,
  input  logic          timeout,
  output logic [CW-1:0] count,
  output logic          qualified
);
  localparam logic [CW-1:0] FULL = CW'(RUN_LEN);

  logic [CW-1:0] count_q;
  logic [CW-1:0] count_d;
  logic          qual_q;

  always_comb begin
    if (!rx_mode)            count_d = '0;
    else if (edge_in) begin
      if (timeout)           count_d = CW'(1);
      else if (count_q == FULL) count_d = FULL;
      else                   count_d = count_q + CW'(1);
    end
    else if (timeout)        count_d = '0;
    else                     count_d = count_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      qual_q  <= 1'b0;
    end else begin
      count_q <= count_d;
      qual_q  <= rx_mode && (count_d == FULL);
    end
  end

  assign count     = count_q;
  assign qualified = qual_q;
endmodule

// File: rtl/carrier_qual.sv
module carrier_qual #(
  parameter int RUN_LEN     = 4,
  parameter int GAP_CYCLES  = 1152,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rts_n,
  input  logic cmp_in,
  output logic carrier_ok
);
  localparam int CNT_W = cdq_pkg::cdq_width(RUN_LEN);
  localparam int GAP_W = cdq_pkg::cdq_width(GAP_CYCLES);

  logic             edge_pulse;
  logic             gap_expired;
  logic [CNT_W-1:0] run_cnt;

  cdq_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (cmp_in),
    .rise (edge_pulse)
  );

  cdq_gap_timer #(.GAP_CYCLES(GAP_CYCLES), .TW(GAP_W)) u_gap (
    .clk     (clk),
    .rst     (rst),
    .restart (edge_pulse),
    .expired (gap_expired)
  );

  cdq_run_counter #(.RUN_LEN(RUN_LEN), .CW(CNT_W)) u_run (
    .clk       (clk),
    .rst       (rst),
    .rx_mode   (rts_n),
    .edge_in   (edge_pulse),
    .timeout   (gap_expired),
    .count     (run_cnt),
    .qualified (carrier_ok)
  );
endmodule

// File: rtl/cdq_checks.sv
module cdq_checks #(
  parameter int RUN_LEN = 4,
  parameter int CNT_W   = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             rts_n,
  input logic             edge_pulse,
  input logic             gap_expired,
  input logic [CNT_W-1:0] run_cnt,
  input logic             carrier_ok
);
  AST_TX_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
    !rts_n |=> !carrier_ok); // R2

  AST_TX_CLEARS_COUNT: assert property (@(posedge clk) disable iff (rst)
    !rts_n |=> (run_cnt == '0)); // R2

  AST_RISE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(carrier_ok) |-> ($past(edge_pulse) && $past(rts_n))); // R1

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= CNT_W'(RUN_LEN)); // R1

  AST_LATE_EDGE_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    (gap_expired && edge_pulse && rts_n) |=> (run_cnt == CNT_W'(1))); // R4

  AST_TIMEOUT_DROPS: assert property (@(posedge clk) disable iff (rst)
    (gap_expired && !edge_pulse) |=> (!carrier_ok && run_cnt == '0)); // R5

  AST_FLAG_NEEDS_FULL_RUN: assert property (@(posedge clk) disable iff (rst)
    carrier_ok |-> (run_cnt == CNT_W'(RUN_LEN))); // R1
endmodule

bind carrier_qual cdq_checks #(.RUN_LEN(RUN_LEN), .CNT_W(CNT_W)) u_checks (
  .clk         (clk),
  .rst         (rst),
  .rts_n       (rts_n),
  .edge_pulse  (edge_pulse),
  .gap_expired (gap_expired),
  .run_cnt     (run_cnt),
  .carrier_ok  (carrier_ok)
);

// File: tb/carrier_qual_test.sv
module carrier_qual_test;
  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 1152;
  localparam int MARK_SP    = 384;
  localparam int SPACE_SP   = 209;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rts_n = 1'b1;
  logic cmp_in = 1'b0;
  logic carrier_ok;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  carrier_qual uut (
    .clk        (clk),
    .rst        (rst),
    .rts_n      (rts_n),
    .cmp_in     (cmp_in),
    .carrier_ok (carrier_ok)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic exp, input string req, input string what);
    checks++;
    if (carrier_ok !== exp) begin
      failures++;
      $display("FAIL %s: %s carrier_ok got %0b expected %0b", req, what, carrier_ok, exp);
    end
  endtask

  // One comparator pulse: rises now, high for 'high' cycles, next rise 'spacing' cycles later
  task automatic pulse(input int spacing, input int high);
    cmp_in = 1'b1;
    repeat (high) @(negedge clk);
    cmp_in = 1'b0;
    repeat (spacing - high) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rts_n = 1'b1; cmp_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check(1'b0, "R7", "after reset");
    for (int i = 0; i < 4; i++) pulse(MARK_SP, MARK_SP/2);
    check(1'b1, "R1", "four edges before reset");
    rst = 1'b1;
    @(negedge clk);
    check(1'b0, "R7", "during reset");
    rst = 1'b0;
    pulse(MARK_SP, MARK_SP/2);
    check(1'b0, "R7", "one edge after reset, count cleared");
  endtask

  task automatic t_rate(input int sp, input string tag);
    do_reset();
    for (int i = 0; i < 3; i++) pulse(sp, sp/2);
    check(1'b0, "R1", {tag, " three edges"});
    pulse(sp, sp/2);
    check(1'b1, "R3", {tag, " four edges"});
    for (int i = 0; i < 6; i++) pulse(sp, sp/2);
    check(1'b1, "R3", {tag, " sustained train"});
  endtask

  task automatic t_boundary();
    do_reset();
    for (int i = 0; i < 3; i++) pulse(GAP, 100);
    check(1'b0, "R4", "three edges at gap limit");
    pulse(GAP, 100);
    check(1'b1, "R4", "four edges at gap limit spacing");
    @(negedge clk);
    check(1'b1, "R4", "flag held just before late edge");
    pulse(MARK_SP, MARK_SP/2);
    check(1'b0, "R4", "edge at limit+1 restarts run");
    pulse(MARK_SP, MARK_SP/2);
    pulse(MARK_SP, MARK_SP/2);
    check(1'b0, "R4", "late edge plus two");
    pulse(MARK_SP, MARK_SP/2);
    check(1'b1, "R4", "late edge counted as first of new run");
  endtask

  task automatic t_timeout();
    do_reset();
    for (int i = 0; i < 4; i++) pulse(MARK_SP, MARK_SP/2);
    check(1'b1, "R5", "qualified before silence");
    repeat (GAP + 2 - MARK_SP) @(negedge clk);
    check(1'b1, "R5", "still high at gap limit");
    repeat (2) @(negedge clk);
    check(1'b0, "R5", "dropped after gap limit");
    for (int i = 0; i < 3; i++) pulse(SPACE_SP, SPACE_SP/2);
    check(1'b0, "R5", "three fresh edges after drop");
    pulse(SPACE_SP, SPACE_SP/2);
    check(1'b1, "R5", "four fresh edges after drop");
  endtask

  task automatic t_tx_block();
    do_reset();
    for (int i = 0; i < 4; i++) pulse(MARK_SP, MARK_SP/2);
    check(1'b1, "R2", "qualified in receive mode");
    rts_n = 1'b0;
    @(negedge clk);
    check(1'b0, "R2", "transmit mode clears flag");
    for (int i = 0; i < 5; i++) pulse(SPACE_SP, SPACE_SP/2);
    check(1'b0, "R2", "edges during transmit");
    rts_n = 1'b1;
    for (int i = 0; i < 3; i++) pulse(SPACE_SP, SPACE_SP/2);
    check(1'b0, "R2", "three edges after transmit ends");
    pulse(SPACE_SP, SPACE_SP/2);
    check(1'b1, "R2", "four edges after transmit ends");
  endtask

  task automatic t_level();
    do_reset();
    pulse(MARK_SP, MARK_SP/2);
    pulse(MARK_SP, MARK_SP/2);
    cmp_in = 1'b1;
    repeat (1050) @(negedge clk);
    check(1'b0, "R6", "long high level counted once");
    cmp_in = 1'b0;
    repeat (50) @(negedge clk);
    check(1'b0, "R6", "after long level");
    pulse(MARK_SP, MARK_SP/2);
    check(1'b1, "R6", "next edge is the fourth");
  endtask

  initial begin
    t_reset();
    t_rate(MARK_SP, "1200 Hz");
    t_rate(SPACE_SP, "2200 Hz");
    t_boundary();
    t_timeout();
    t_tx_block();
    t_level();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule